// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a 16-bit timer for a small microcontroller. A free-running up-counter advances once every four system clocks through a fixed prescaler. Two capture channels record the counter value when a selected edge appears on their input pins. Two compare channels apply a selected action to their output pins when the counter reaches a programmed value. Every event sets a flag. Each flag has an enable bit, and the enabled flags are combined into one interrupt line.

The CPU reaches the block through an 8-bit register port. Every counter-wide value is split into a high byte and a low byte. The byte pairs follow a coherence rule. Reading a capture high byte stops new captures on that channel until its low byte is read. Writing a compare high byte disarms matching until the low byte is written. Reading the counter high byte freezes the matching low byte for the next low-byte read. A read takes effect at the clock edge where `rd_i` is high, and its data is presented on `rdata_o` from that edge until the next read.

The counter width `CNT_W` can be set from 9 to 16 bits (default 16). The high byte holds bits `CNT_W-1:8`, and its unused upper bits read as zero.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter is 0. It increments by one, modulo 2^CNT_W, at every fourth clock edge, and it changes at no other time.
- R2: When the counter wraps from all-ones to zero, flag bit 4 (overflow) is set.
- R3: A read of the counter high byte (address 3) holds the counter's low byte at that same edge. The next read of the counter low byte (address 4) returns the held byte. A low-byte read that no high-byte read preceded returns the live low byte.
- R4: Capture channel k (k = 0, 1) takes its edge select from control bits [2k+1:2k], where 00 = off, 01 = rising, 10 = falling and 11 = both. A selected edge on `cap_i[k]` stores the counter into capture k and sets flag bit k. The store happens at the third clock edge after the pin change: two synchroniser stages and one edge stage. Capture k reads at address 5+2k (high byte) and 6+2k (low byte).
- R5: Reading the capture k high byte blocks capture k, and its flag, from that edge until the capture k low byte is read.
- R6: Writing the compare j high byte (address 9+2j) disarms compare j. Writing the low byte (address 10+2j) re-arms it.
- R7: Compare j takes its action from control bits [5+2j:4+2j], where 00 = none, 01 = toggle, 10 = drive low and 11 = drive high. The action is applied to `cmp_o[j]` and flag bit 2+j is set. This happens at the prescaled tick on which an armed compare j equals the counter, and `cmp_o` changes at no other time.
- R8: The flag register (address 2) clears each bit written as 1. A flag set in the same cycle stays set.
- R9: `irq_o` is high exactly when some flag bit and its enable bit (address 1, same bit positions) are both 1.
- R10: Reset sets the control register (address 0), the enables, the flags, the captures, `cmp_o`, `irq_o` and `rdata_o` to zero. It sets both compare registers to all ones and armed.
- R11: Writes to the counter and capture addresses, and to addresses 13 to 15, change nothing. Reads of addresses 13 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, updated at each read edge |
| cap_i | input | 2 | Capture input pins, asynchronous |
| cmp_o | output | 2 | Compare output pins |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets the byte-pair rules. It reads a counter high byte, waits many ticks and then reads the low byte. A design without the holding register returns a low byte far ahead of the high byte. It drives a capture edge between a high-byte read and a low-byte read. A design that ignores the lock overwrites the value half-read by software. It writes only a compare high byte across a match time. A design that does not disarm toggles the pin on a half-written value. It also covers edges that a mode must ignore, set-and-clear collisions on the flag register, and the counter wrap. Errors in capture latency or tick alignment show up as cycle mismatches against the bench's reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_CAP = 2;
  localparam int N_CMP = 2;
  localparam int NFLAG = N_CAP + N_CMP + 1;
  localparam int FLG_OVF = N_CAP + N_CMP;

  localparam logic [3:0] ADR_CTRL     = 4'h0;
  localparam logic [3:0] ADR_IEN      = 4'h1;
  localparam logic [3:0] ADR_FLAG     = 4'h2;
  localparam logic [3:0] ADR_CNT_H    = 4'h3;
  localparam logic [3:0] ADR_CNT_L    = 4'h4;
  localparam int         ADR_CAP_BASE = 5;
  localparam int         ADR_CMP_BASE = 9;

  typedef enum logic [1:0] {EDGE_OFF = 2'b00, EDGE_RISE = 2'b01, EDGE_FALL = 2'b10, EDGE_ANY = 2'b11} edge_sel_e;
  typedef enum logic [1:0] {ACT_NONE = 2'b00, ACT_TOGGLE = 2'b01, ACT_CLEAR = 2'b10, ACT_SET = 2'b11} cmp_act_e;
endpackage

// File: rtl/tmr_base.sv
module tmr_base #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0]  pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (pre_q == PS_W'(PRESCALE - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_icap.sv
module tmr_icap
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic [CNT_W-1:0] val_o,
  output logic             lock_o,
  output logic             hit_o
);
  logic sync1_q, sync2_q, prev_q;
  logic rise, fall, trig;
  logic [CNT_W-1:0] val_q;
  logic lock_q;

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  always_comb begin
    unique case (edge_sel_e'(sel_i))
      EDGE_RISE: trig = rise;
      EDGE_FALL: trig = fall;
      EDGE_ANY:  trig = rise | fall;
      default:   trig = 1'b0;
    endcase
  end

  // a high-byte read in progress also blocks, so the pair stays coherent
  assign hit_o  = trig & ~lock_q & ~rd_hi_i;
  assign val_o  = val_q;
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      val_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (hit_o) val_q <= cnt_i;
      if (rd_hi_i)      lock_q <= 1'b1;
      else if (rd_lo_i) lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_ocmp.sv
module tmr_ocmp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HI_W = CNT_W - 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       act_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [HI_W-1:0]  hi_i,
  input  logic [7:0]       lo_i,
  output logic [CNT_W-1:0] val_o,
  output logic             pin_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] val_q;
  logic armed_q, pin_q;

  assign hit_o = tick_i & armed_q & (cnt_i == val_q);
  assign val_o = val_q;
  assign pin_o = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '1;
      armed_q <= 1'b1;
      pin_q   <= 1'b0;
    end else begin
      if (hit_o) begin
        unique case (cmp_act_e'(act_i))
          ACT_TOGGLE: pin_q <= ~pin_q;
          ACT_CLEAR:  pin_q <= 1'b0;
          ACT_SET:    pin_q <= 1'b1;
          default:    pin_q <= pin_q;
        endcase
      end
      if (wr_hi_i) begin
        val_q[CNT_W-1:8] <= hi_i;
        armed_q          <= 1'b0;
      end else if (wr_lo_i) begin
        val_q[7:0] <= lo_i;
        armed_q    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [1:0] cap_i,
  output logic [1:0] cmp_o,
  output logic       irq_o
);
  localparam int HI_W = CNT_W - 8;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctrl_q;
  logic [NFLAG-1:0] ien_q, flags_q, flag_set, flag_clr;
  logic [7:0]       rdata_q, rd_val, hold_q;
  logic             hold_v_q;

  logic [CNT_W-1:0]       cap_val [N_CAP];
  logic [N_CAP-1:0]       cap_hit, cap_lock;
  logic [N_CAP*CNT_W-1:0] cap_flat;
  logic [CNT_W-1:0]       cmp_val [N_CMP];
  logic [N_CMP-1:0]       cmp_hit;

  tmr_base #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick),
    .cnt_o (cnt)
  );

  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    tmr_icap #(.CNT_W(CNT_W)) u_icap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[k]),
      .sel_i  (ctrl_q[2*k +: 2]),
      .cnt_i  (cnt),
      .rd_hi_i(rd_en_i && addr_i == 4'(ADR_CAP_BASE + 2*k)),
      .rd_lo_i(rd_en_i && addr_i == 4'(ADR_CAP_BASE + 2*k + 1)),
      .val_o  (cap_val[k]),
      .lock_o (cap_lock[k]),
      .hit_o  (cap_hit[k])
    );
    assign cap_flat[k*CNT_W +: CNT_W] = cap_val[k];
  end

  for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
    tmr_ocmp #(.CNT_W(CNT_W)) u_ocmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (ctrl_q[2*N_CAP + 2*j +: 2]),
      .tick_i (tick),
      .cnt_i  (cnt),
      .wr_hi_i(wr_en_i && addr_i == 4'(ADR_CMP_BASE + 2*j)),
      .wr_lo_i(wr_en_i && addr_i == 4'(ADR_CMP_BASE + 2*j + 1)),
      .hi_i   (wdata_i[HI_W-1:0]),
      .lo_i   (wdata_i),
      .val_o  (cmp_val[j]),
      .pin_o  (cmp_o[j]),
      .hit_o  (cmp_hit[j])
    );
  end

  assign flag_set = {tick && (cnt == '1), cmp_hit, cap_hit};
  assign flag_clr = (wr_en_i && addr_i == ADR_FLAG) ? wdata_i[NFLAG-1:0] : '0;

  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      ADR_CTRL:  rd_val = ctrl_q;
      ADR_IEN:   rd_val = 8'(ien_q);
      ADR_FLAG:  rd_val = 8'(flags_q);
      ADR_CNT_H: rd_val = 8'(cnt[CNT_W-1:8]);
      ADR_CNT_L: rd_val = hold_v_q ? hold_q : cnt[7:0];
      default: begin
        for (int k = 0; k < N_CAP; k++) begin
          if (addr_i == 4'(ADR_CAP_BASE + 2*k))     rd_val = 8'(cap_val[k][CNT_W-1:8]);
          if (addr_i == 4'(ADR_CAP_BASE + 2*k + 1)) rd_val = cap_val[k][7:0];
        end
        for (int j = 0; j < N_CMP; j++) begin
          if (addr_i == 4'(ADR_CMP_BASE + 2*j))     rd_val = 8'(cmp_val[j][CNT_W-1:8]);
          if (addr_i == 4'(ADR_CMP_BASE + 2*j + 1)) rd_val = cmp_val[j][7:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      flags_q  <= '0;
      rdata_q  <= '0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      if (wr_en_i && addr_i == ADR_CTRL) ctrl_q <= wdata_i;
      if (wr_en_i && addr_i == ADR_IEN)  ien_q  <= wdata_i[NFLAG-1:0];
      if (rd_en_i) begin
        rdata_q <= rd_val;
        if (addr_i == ADR_CNT_H) begin
          hold_q   <= cnt[7:0];
          hold_v_q <= 1'b1;
        end else if (addr_i == ADR_CNT_L) begin
          hold_v_q <= 1'b0;
        end
      end
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(flags_q & ien_q);
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick_i,
  input logic [CNT_W-1:0]       cnt_i,
  input logic [NFLAG-1:0]       flags_i,
  input logic [N_CAP*CNT_W-1:0] cap_flat_i,
  input logic [N_CAP-1:0]       cap_lock_i,
  input logic [1:0]             cmp_i,
  input logic                   irq_i
);
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  p_cnt_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> $past(tick_i));

  p_ovf_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == {CNT_W{1'b1}}) |=> flags_i[FLG_OVF]);

  for (genvar k = 0; k < N_CAP; k++) begin : g_lock
    p_cap_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_lock_i[k] |=> $stable(cap_flat_i[k*CNT_W +: CNT_W]));
  end

  p_cmp_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_i) |-> $past(tick_i));

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flags_i != '0));
endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .cnt_i     (cnt),
  .flags_i   (flags_q),
  .cap_flat_i(cap_flat),
  .cap_lock_i(cap_lock),
  .cmp_i     (cmp_o),
  .irq_i     (irq_o)
);

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  localparam int TW   = 12;
  localparam int MASK = (1 << TW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cap = '0;
  logic [1:0] cmp;
  logic       irq;

  int    n_tests = 0, n_fail = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  tmr_top #(.CNT_W(TW), .PRESCALE(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
  );

  // behavioural reference
  int m_pre = 0, m_cnt = 0, m_ctrl = 0, m_ien = 0, m_flags = 0, m_rdata = 0;
  int m_hold = 0, m_hold_v = 0;
  int m_cap[2] = '{0, 0}, m_lock[2] = '{0, 0};
  int m_cmp[2] = '{MASK, MASK}, m_arm[2] = '{1, 1}, m_pin[2] = '{0, 0};
  int m_hist[2][$];

  initial for (int i = 0; i < 2; i++) m_hist[i] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ctrl = 0; m_ien = 0; m_flags = 0; m_rdata = 0;
      m_hold = 0; m_hold_v = 0;
      for (int i = 0; i < 2; i++) begin
        m_cap[i] = 0; m_lock[i] = 0; m_cmp[i] = MASK; m_arm[i] = 1; m_pin[i] = 0;
        m_hist[i] = '{0, 0, 0};
      end
    end else begin
      automatic int tick = (m_pre == 3);
      automatic int sets = 0;
      automatic int clr = (wr && addr == 2) ? int'(wdata) : 0;
      automatic int a = int'(addr);
      if (rd) begin
        case (a)
          0: m_rdata = m_ctrl;
          1: m_rdata = m_ien;
          2: m_rdata = m_flags;
          3: begin m_rdata = m_cnt >> 8; m_hold = m_cnt & 255; m_hold_v = 1; end
          4: begin m_rdata = m_hold_v ? m_hold : (m_cnt & 255); m_hold_v = 0; end
          5, 7: m_rdata = m_cap[(a - 5) / 2] >> 8;
          6, 8: m_rdata = m_cap[(a - 6) / 2] & 255;
          9, 11: m_rdata = m_cmp[(a - 9) / 2] >> 8;
          10, 12: m_rdata = m_cmp[(a - 10) / 2] & 255;
          default: m_rdata = 0;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        automatic int nw = m_hist[i][1], od = m_hist[i][2];
        automatic int sel = (m_ctrl >> (2 * i)) & 3;
        automatic int rdhi = rd && a == 5 + 2 * i;
        automatic bit trig = (sel == 1 && nw && !od) || (sel == 2 && !nw && od) || (sel == 3 && nw != od);
        if (trig && !m_lock[i] && !rdhi) begin m_cap[i] = m_cnt; sets |= 1 << i; end
        if (rdhi) m_lock[i] = 1;
        else if (rd && a == 6 + 2 * i) m_lock[i] = 0;
        void'(m_hist[i].pop_back());
        m_hist[i].push_front(int'(cap[i]));
      end
      for (int j = 0; j < 2; j++) begin
        automatic int act = (m_ctrl >> (4 + 2 * j)) & 3;
        if (tick && m_arm[j] && m_cnt == m_cmp[j]) begin
          if (act == 1) m_pin[j] = !m_pin[j];
          else if (act == 2) m_pin[j] = 0;
          else if (act == 3) m_pin[j] = 1;
          sets |= 1 << (2 + j);
        end
        if (wr && a == 9 + 2 * j) begin
          m_cmp[j] = (m_cmp[j] & 255) | ((int'(wdata) & (MASK >> 8)) << 8); m_arm[j] = 0;
        end else if (wr && a == 10 + 2 * j) begin
          m_cmp[j] = (m_cmp[j] & ~255) | int'(wdata); m_arm[j] = 1;
        end
      end
      if (tick) begin
        if (m_cnt == MASK) sets |= 16;
        m_cnt = (m_cnt + 1) & MASK;
      end
      m_pre = (m_pre + 1) % 4;
      if (wr && a == 0) m_ctrl = int'(wdata);
      if (wr && a == 1) m_ien = int'(wdata) & 31;
      m_flags = (m_flags & ~clr & 31) | sets;
    end
  end

  task automatic check(string req, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (chk_on) begin
      check(cur_req, int'(rdata), m_rdata);
      check("R7", int'(cmp), (m_pin[1] << 1) | m_pin[0]);
      check("R9", int'(irq), (m_flags & m_ien) != 0);
    end
  end

  task automatic rd_reg(input int a, output int v);
    @(negedge clk); addr = 4'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = int'(rdata);
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); addr = 4'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, v2, h, c, t, c0;
    idle(3);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R10 reset state
    check("R10", int'(cmp), 0);
    check("R10", int'(irq), 0);
    rd_reg(0, v); check("R10", v, 0);
    rd_reg(2, v); check("R10", v, 0);
    rd_reg(9, v); check("R10", v, MASK >> 8);
    rd_reg(10, v); check("R10", v, 255);
    rd_reg(8, v); check("R10", v, 0);

    // R1 counter rate
    cur_req = "R1";
    rd_reg(4, v); idle(14); rd_reg(4, v2);
    check("R1", (v2 - v) & 255, 4);

    // R3 coherent counter read
    cur_req = "R3";
    rd_reg(3, h); idle(40); rd_reg(4, v); rd_reg(4, v2);
    check("R3", int'(((v2 - v) & 255) >= 10 && ((v2 - v) & 255) <= 12), 1);

    // R4 edge selects
    cur_req = "R4";
    wr_reg(0, 8'h09);                       // cap0 rising, cap1 falling
    @(negedge clk); cap[1] = 1'b1; idle(6); // rising on a falling-only channel
    rd_reg(2, v); check("R4", v & 3, 0);
    @(negedge clk); cap[0] = 1'b1; idle(6);
    rd_reg(2, v); check("R4", v & 3, 1);
    rd_reg(6, v);
    @(negedge clk); cap[1] = 1'b0; idle(6);
    rd_reg(2, v); check("R4", v & 3, 3);
    rd_reg(8, v);
    wr_reg(0, 8'h03);                       // cap0 both, cap1 off
    wr_reg(2, 8'h03);
    @(negedge clk); cap[0] = 1'b0; cap[1] = 1'b1; idle(6);
    rd_reg(2, v); check("R4", v & 3, 1);

    // R5 capture lock
    cur_req = "R5";
    wr_reg(0, 8'h01);
    rd_reg(6, c0);
    wr_reg(2, 8'h01);
    rd_reg(5, h);
    @(negedge clk); cap[0] = 1'b1; idle(6);
    rd_reg(2, v); check("R5", v & 1, 0);
    rd_reg(6, v); check("R5", v, c0);
    @(negedge clk); cap[0] = 1'b0; idle(4);
    @(negedge clk); cap[0] = 1'b1; idle(6);
    rd_reg(2, v); check("R5", v & 1, 1);

    // R7 compare toggle on cmp0, set on cmp1
    cur_req = "R7";
    wr_reg(0, 8'hD0);
    wr_reg(2, 8'h1F);
    rd_reg(3, h); rd_reg(4, v); c = (h << 8) | v;
    t = (c + 20) & MASK;
    wr_reg(9, t >> 8); wr_reg(10, t & 255);
    wr_reg(11, t >> 8); wr_reg(12, t & 255);
    idle(100);
    check("R7", int'(cmp), 3);
    rd_reg(2, v); check("R7", v & 12, 12);

    // R6 high-byte write disarms
    cur_req = "R6";
    wr_reg(0, 8'h10);
    rd_reg(3, h); rd_reg(4, v); c = (h << 8) | v;
    t = (c + 20) & MASK;
    wr_reg(2, 8'h1F);
    wr_reg(10, t & 255);                    // low first, then high: disarmed
    wr_reg(9, t >> 8);
    idle(100);
    check("R6", int'(cmp[0]), 1);
    rd_reg(2, v); check("R6", v & 4, 0);

    // R7 clear action, and none
    cur_req = "R7";
    wr_reg(0, 8'h20);
    rd_reg(3, h); rd_reg(4, v); c = (h << 8) | v;
    t = (c + 20) & MASK;
    wr_reg(9, t >> 8); wr_reg(10, t & 255);
    wr_reg(11, t >> 8); wr_reg(12, t & 255);
    idle(100);
    check("R7", int'(cmp), 2);

    // R8 write-one-to-clear
    cur_req = "R8";
    rd_reg(2, v); check("R8", v & 12, 12);
    wr_reg(2, 8'h04);
    rd_reg(2, v); check("R8", v & 12, 8);

    // R9 interrupt combine
    cur_req = "R9";
    wr_reg(1, 8'h08); idle(1); check("R9", int'(irq), 1);
    wr_reg(1, 8'h04); idle(1); check("R9", int'(irq), 0);
    wr_reg(1, 8'h00);

    // R11 read-only and unmapped addresses
    cur_req = "R11";
    rd_reg(6, c0);
    wr_reg(6, 8'h5A); wr_reg(5, 8'h0A);
    rd_reg(6, v); check("R11", v, c0);
    wr_reg(13, 8'hFF); rd_reg(13, v); check("R11", v, 0);
    wr_reg(4, 8'h00); wr_reg(3, 8'h00);
    rd_reg(4, v); idle(14); rd_reg(4, v2);
    check("R11", (v2 - v) & 255, 4);

    // R2 wrap sets overflow
    cur_req = "R2";
    wr_reg(2, 8'h1F);
    idle(4 * (MASK + 1) + 20);
    rd_reg(2, v); check("R2", (v >> 4) & 1, 1);

    idle(2);
    finish_run();
  end
endmodule